// File: doc/BRIEF.md
# Receive Descriptor Ring Manager with Pause Thresholds

This block sits behind a receive MAC and fills a ring of 256 receive buffers, each 2048 bytes long. Frames arrive as a byte stream (valid, data, last) that cannot be stalled. Each byte goes to the buffer owned by the current descriptor. When a frame ends and is accepted, the block writes the frame length into that descriptor's status word. It then advances the descriptor write pointer, which wraps after the last descriptor, and bumps a 16-bit producer index that the host reads. The host hands buffers back by writing a consumer index. The gap between the producer and consumer indices is the ring occupancy.

A frame is dropped whole if it arrives when no descriptor is free, or if it carries more data bytes than the programmed maximum. A wrapping drop counter records each drop. An optional alignment mode puts two unwritten pad bytes in front of the frame data and counts them in the reported length. Two thresholds on the number of free descriptors raise a one-cycle pause-on request and, later, a one-cycle pause-off request. The block also keeps a level that shows the paused condition.

The frame state machine has three states:
- RX_IDLE waits for a first byte. A first byte that is also the last byte is resolved in RX_IDLE.
- RX_STORE writes bytes into the buffer.
- RX_DISCARD swallows a frame that found no free descriptor.

Its transitions are:
- RX_IDLE to RX_STORE: a first byte arrives while a descriptor is free.
- RX_IDLE to RX_DISCARD: a first byte arrives while no descriptor is free.
- RX_STORE to RX_IDLE and RX_DISCARD to RX_IDLE: the last byte arrives.

The flow-control state machine has two states, FC_OPEN and FC_HOLD:
- FC_OPEN to FC_HOLD (pause on): the free count falls to the low threshold or below.
- FC_HOLD to FC_OPEN (pause off): the free count rises to the high threshold or above.

Top module: `rx_ring_mgr`

## Requirements
- R1: After reset the producer index, descriptor write pointer, consumer index and drop count are 0. No buffer or descriptor write is issued and the block is not paused. The configuration holds alignment off, maximum length 1536, low threshold 5 and high threshold 16.
- R2: Each accepted frame produces exactly one descriptor write, one cycle after its last byte. The write goes to the current write-pointer index, with the reported length in status bits 27:16 and all other status bits 0.
- R3: Data byte k of a frame is written to buffer address index*2048 + pad + k, where pad is 0 or 2. Bytes whose offset would reach 2048 or more are not written, but they are still counted in the reported length.
- R4: The producer index rises by one per accepted frame and wraps at 65536. The descriptor write pointer advances with it and wraps from 255 to 0.
- R5: Configuration address 0, bit 1, enables alignment. The pad is then 2, and the reported length is the data byte count plus 2. The setting is sampled at each frame's first byte.
- R6: A frame whose data byte count exceeds the maximum length (address 1, bits 11:0) produces no descriptor write and leaves the producer index unchanged. The drop count rises by 1. A frame of exactly the maximum length is accepted.
- R7: The free count is 256 minus ((producer - consumer) mod 65536), and is 0 when that occupancy is 256 or more. A frame whose first byte arrives with a free count of 0 is dropped with no buffer write, and the drop count rises by 1.
- R8: While not paused, a free count at or below the low threshold (address 2, bits 31:16) gives a one-cycle pause-on pulse and sets the paused level.
- R9: While paused, a free count at or above the high threshold (address 2, bits 15:0) gives a one-cycle pause-off pulse and clears the paused level.
- R10: A write to configuration address 3 loads the consumer index from bits 15:0, and the free count follows on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration address: 0 control, 1 max length, 2 thresholds, 3 consumer index |
| cfg_wdata | input | 32 | Configuration write data |
| in_valid | input | 1 | Byte valid |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Last byte of the frame |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 19 | Buffer byte address, descriptor index in bits 18:11 |
| buf_wdata | output | 8 | Buffer write byte |
| desc_we | output | 1 | Descriptor status write strobe |
| desc_idx | output | 8 | Descriptor being written |
| desc_status | output | 32 | Status word, length in bits 27:16 |
| prod_idx | output | 16 | Producer index |
| xoff_req | output | 1 | Pause-on request pulse |
| xon_req | output | 1 | Pause-off request pulse |
| paused | output | 1 | Paused level |
| drop_count | output | 16 | Count of dropped frames, wrapping |

## Verification
The bench goes after several corner cases:
- A frame of exactly the maximum length next to one a byte longer. Getting the comparison wrong either drops a legal frame or commits an oversize one.
- A frame that runs past the end of the 2048-byte buffer. A wrong bound would spill bytes into the neighbouring descriptor's buffer.
- A one-byte frame, whose first byte is also its last and is resolved in RX_IDLE.
- The fill to exactly 256 outstanding frames, and the frame that follows. A design with an off-by-one free count would either take a frame with nowhere to put it or refuse one too early.
- Descriptor 255 followed by descriptor 0.
- Consumer writes that move the free count across both thresholds, including a consumer value ahead of the producer. An error in the modulo or the floor would miss the pause pulses or accept into a full ring.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [1:0] {
        RX_IDLE    = 2'd0,
        RX_STORE   = 2'd1,
        RX_DISCARD = 2'd2
    } rx_state_t;

    typedef enum logic {
        FC_OPEN = 1'b0,
        FC_HOLD = 1'b1
    } fc_state_t;

    localparam logic [1:0] CFG_CTRL   = 2'd0;
    localparam logic [1:0] CFG_MAXLEN = 2'd1;
    localparam logic [1:0] CFG_THRESH = 2'd2;
    localparam logic [1:0] CFG_CONS   = 2'd3;

    localparam int ALIGN_BIT  = 1;
    localparam int STAT_W     = 32;
    localparam int LEN_LSB    = 16;
    localparam int THR_W      = 16;

endpackage

// File: rtl/rxr_cfg_regs.sv
module rxr_cfg_regs
    import rxr_pkg::*;
#(
    parameter int IDX_W       = 16,
    parameter int LEN_W       = 12,
    parameter int DEF_MAX_LEN = 1536,
    parameter int DEF_LO      = 5,
    parameter int DEF_HI      = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic             align_en,
    output logic [LEN_W-1:0] max_len,
    output logic [THR_W-1:0] thr_lo,
    output logic [THR_W-1:0] thr_hi,
    output logic [IDX_W-1:0] cons_idx
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            align_en <= 1'b0;
            max_len  <= LEN_W'(DEF_MAX_LEN);
            thr_lo   <= THR_W'(DEF_LO);
            thr_hi   <= THR_W'(DEF_HI);
            cons_idx <= '0;
        end else if (cfg_we) begin
            unique case (cfg_addr)
                CFG_CTRL:   align_en <= cfg_wdata[ALIGN_BIT];
                CFG_MAXLEN: max_len  <= cfg_wdata[LEN_W-1:0];
                CFG_THRESH: begin
                    thr_lo <= cfg_wdata[31:16];
                    thr_hi <= cfg_wdata[15:0];
                end
                CFG_CONS:   cons_idx <= cfg_wdata[IDX_W-1:0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
    parameter int DESC_NUM = 256,
    parameter int IDX_W    = 16,
    localparam int DESC_W  = $clog2(DESC_NUM),
    localparam int FREE_W  = DESC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  logic [IDX_W-1:0]  cons_idx,
    output logic [IDX_W-1:0]  prod_idx,
    output logic [DESC_W-1:0] wr_ptr,
    output logic [FREE_W-1:0] free_cnt
);

    logic [IDX_W-1:0]  occupancy;
    logic [DESC_W-1:0] ptr_next;

    // Occupancy is taken modulo the index width; anything at or above the
    // ring size leaves no room.
    assign occupancy = prod_idx - cons_idx;

    always_comb begin
        if (occupancy >= IDX_W'(DESC_NUM)) begin
            free_cnt = '0;
        end else begin
            free_cnt = FREE_W'(IDX_W'(DESC_NUM) - occupancy);
        end
    end

    generate
        if ((DESC_NUM & (DESC_NUM - 1)) == 0) begin : g_pow2_wrap
            assign ptr_next = wr_ptr + 1'b1;
        end else begin : g_cmp_wrap
            assign ptr_next = (wr_ptr == DESC_W'(DESC_NUM - 1)) ? '0 : wr_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prod_idx <= '0;
            wr_ptr   <= '0;
        end else if (commit) begin
            prod_idx <= prod_idx + 1'b1;
            wr_ptr   <= ptr_next;
        end
    end

endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
    import rxr_pkg::*;
#(
    parameter int DESC_NUM  = 256,
    parameter int BUF_BYTES = 2048,
    parameter int LEN_W     = 12,
    parameter int PAD_BYTES = 2,
    parameter int CNT_W     = 16,
    localparam int DESC_W   = $clog2(DESC_NUM),
    localparam int OFF_W    = $clog2(BUF_BYTES),
    localparam int ADDR_W   = DESC_W + OFF_W,
    localparam int FREE_W   = DESC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    input  logic              align_en,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic [DESC_W-1:0] wr_ptr,
    output logic              commit_now,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              desc_we,
    output logic [DESC_W-1:0] desc_idx,
    output logic [STAT_W-1:0] desc_status,
    output logic [CNT_W-1:0]  drop_count
);

    localparam logic [LEN_W-1:0] LEN_SAT = '1;

    rx_state_t        state, state_nx;
    logic [LEN_W-1:0] cnt;
    logic             pad_on_q;

    logic             pad_on;
    logic [LEN_W-1:0] pad_len;
    logic [LEN_W-1:0] cur_cnt;
    logic [LEN_W-1:0] cnt_nx;
    logic [LEN_W-1:0] rep_len;
    logic [LEN_W:0]   offset;
    logic             room;
    logic             accept;
    logic             len_ok;
    logic             in_buf;
    logic             drop_now;

    // Frame datapath decode
    assign pad_on   = (state == RX_IDLE) ? align_en : pad_on_q;
    assign pad_len  = pad_on ? LEN_W'(PAD_BYTES) : '0;
    assign cur_cnt  = (state == RX_IDLE) ? '0 : cnt;
    assign cnt_nx   = (cur_cnt == LEN_SAT) ? cur_cnt : cur_cnt + 1'b1;
    assign rep_len  = cnt_nx + pad_len;
    assign offset   = {1'b0, cur_cnt} + {1'b0, pad_len};
    assign in_buf   = offset < (LEN_W + 1)'(BUF_BYTES);
    assign room     = (free_cnt != '0);
    assign accept   = in_valid && ((state == RX_STORE) || ((state == RX_IDLE) && room));
    assign len_ok   = (cnt_nx <= max_len);

    assign commit_now = accept && in_last && len_ok;
    assign drop_now   = in_valid && in_last && !commit_now;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= RX_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            RX_IDLE: begin
                if (in_valid && !in_last) begin
                    state_nx = room ? RX_STORE : RX_DISCARD;
                end
            end
            RX_STORE, RX_DISCARD: begin
                if (in_valid && in_last) begin
                    state_nx = RX_IDLE;
                end
            end
            default: state_nx = RX_IDLE;
        endcase
    end

    // Registered outputs and frame counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            buf_we      <= 1'b0;
            buf_addr    <= '0;
            buf_wdata   <= '0;
            desc_we     <= 1'b0;
            desc_idx    <= '0;
            desc_status <= '0;
            drop_count  <= '0;
            cnt         <= '0;
            pad_on_q    <= 1'b0;
        end else begin
            buf_we  <= accept && in_buf;
            desc_we <= commit_now;
            if (accept) begin
                buf_addr  <= {wr_ptr, offset[OFF_W-1:0]};
                buf_wdata <= in_data;
            end
            if (commit_now) begin
                desc_idx    <= wr_ptr;
                desc_status <= STAT_W'(rep_len) << LEN_LSB;
            end
            if (in_valid) begin
                cnt <= cnt_nx;
            end
            if (in_valid && (state == RX_IDLE)) begin
                pad_on_q <= align_en;
            end
            if (drop_now) begin
                drop_count <= drop_count + 1'b1;
            end
        end
    end

endmodule

// File: rtl/rxr_pause_ctl.sv
module rxr_pause_ctl
    import rxr_pkg::*;
#(
    parameter int FREE_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FREE_W-1:0] free_cnt,
    input  logic [THR_W-1:0]  thr_lo,
    input  logic [THR_W-1:0]  thr_hi,
    output logic              xoff_req,
    output logic              xon_req,
    output logic              paused
);

    fc_state_t        state, state_nx;
    logic [THR_W-1:0] free_w;

    assign free_w = THR_W'(free_cnt);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= FC_OPEN;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state decode
    always_comb begin
        state_nx = state;
        unique case (state)
            FC_OPEN: if (free_w <= thr_lo) state_nx = FC_HOLD;
            FC_HOLD: if (free_w >= thr_hi) state_nx = FC_OPEN;
            default: state_nx = FC_OPEN;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xoff_req <= 1'b0;
            xon_req  <= 1'b0;
            paused   <= 1'b0;
        end else begin
            xoff_req <= (state == FC_OPEN) && (state_nx == FC_HOLD);
            xon_req  <= (state == FC_HOLD) && (state_nx == FC_OPEN);
            paused   <= (state_nx == FC_HOLD);
        end
    end

endmodule

// File: rtl/rx_ring_mgr.sv
module rx_ring_mgr
    import rxr_pkg::*;
#(
    parameter int DESC_NUM    = 256,
    parameter int BUF_BYTES   = 2048,
    parameter int IDX_W       = 16,
    parameter int LEN_W       = 12,
    parameter int PAD_BYTES   = 2,
    parameter int CNT_W       = 16,
    parameter int DEF_MAX_LEN = 1536,
    parameter int DEF_LO      = 5,
    parameter int DEF_HI      = DESC_NUM / 16,
    localparam int DESC_W     = $clog2(DESC_NUM),
    localparam int OFF_W      = $clog2(BUF_BYTES),
    localparam int ADDR_W     = DESC_W + OFF_W,
    localparam int FREE_W     = DESC_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_addr,
    input  logic [31:0]       cfg_wdata,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    input  logic              in_last,
    output logic              buf_we,
    output logic [ADDR_W-1:0] buf_addr,
    output logic [7:0]        buf_wdata,
    output logic              desc_we,
    output logic [DESC_W-1:0] desc_idx,
    output logic [31:0]       desc_status,
    output logic [IDX_W-1:0]  prod_idx,
    output logic              xoff_req,
    output logic              xon_req,
    output logic              paused,
    output logic [CNT_W-1:0]  drop_count
);

    logic              align_en;
    logic [LEN_W-1:0]  max_len;
    logic [THR_W-1:0]  thr_lo;
    logic [THR_W-1:0]  thr_hi;
    logic [IDX_W-1:0]  cons_idx;
    logic [DESC_W-1:0] wr_ptr;
    logic [FREE_W-1:0] free_cnt;
    logic              commit_now;

    rxr_cfg_regs #(
        .IDX_W       (IDX_W),
        .LEN_W       (LEN_W),
        .DEF_MAX_LEN (DEF_MAX_LEN),
        .DEF_LO      (DEF_LO),
        .DEF_HI      (DEF_HI)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .align_en  (align_en),
        .max_len   (max_len),
        .thr_lo    (thr_lo),
        .thr_hi    (thr_hi),
        .cons_idx  (cons_idx)
    );

    rxr_ring_index #(
        .DESC_NUM (DESC_NUM),
        .IDX_W    (IDX_W)
    ) u_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit   (commit_now),
        .cons_idx (cons_idx),
        .prod_idx (prod_idx),
        .wr_ptr   (wr_ptr),
        .free_cnt (free_cnt)
    );

    rxr_frame_ctl #(
        .DESC_NUM  (DESC_NUM),
        .BUF_BYTES (BUF_BYTES),
        .LEN_W     (LEN_W),
        .PAD_BYTES (PAD_BYTES),
        .CNT_W     (CNT_W)
    ) u_frame (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_last     (in_last),
        .align_en    (align_en),
        .max_len     (max_len),
        .free_cnt    (free_cnt),
        .wr_ptr      (wr_ptr),
        .commit_now  (commit_now),
        .buf_we      (buf_we),
        .buf_addr    (buf_addr),
        .buf_wdata   (buf_wdata),
        .desc_we     (desc_we),
        .desc_idx    (desc_idx),
        .desc_status (desc_status),
        .drop_count  (drop_count)
    );

    rxr_pause_ctl #(
        .FREE_W (FREE_W)
    ) u_pause (
        .clk      (clk),
        .rst_n    (rst_n),
        .free_cnt (free_cnt),
        .thr_lo   (thr_lo),
        .thr_hi   (thr_hi),
        .xoff_req (xoff_req),
        .xon_req  (xon_req),
        .paused   (paused)
    );

endmodule

// File: rtl/rx_ring_mgr_chk.sv
module rx_ring_mgr_chk #(
    parameter int IDX_W = 16,
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] prod_idx,
    input logic             desc_we,
    input logic [31:0]      desc_status,
    input logic [CNT_W-1:0] drop_count,
    input logic             xoff_req,
    input logic             xon_req,
    input logic             paused
);

    // R4: the producer moves only by one, together with a descriptor write
    a_r4_prod_step: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_idx != $past(prod_idx)) |-> ((prod_idx == $past(prod_idx) + 1'b1) && desc_we));

    // R2: status word carries a non-zero length and nothing else
    a_r2_status_clean: assert property (@(posedge clk) disable iff (!rst_n)
        desc_we |-> ((desc_status[31:28] == 4'd0) && (desc_status[15:0] == 16'd0)
                     && (desc_status[27:16] != 12'd0)));

    // R6: a drop moves the counter by one and never coincides with a commit
    a_r6_drop_step: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_count != $past(drop_count)) |-> ((drop_count == $past(drop_count) + 1'b1) && !desc_we));

    // R8: pause-on only from the open condition, and it sets the level
    a_r8_xoff_sets_pause: assert property (@(posedge clk) disable iff (!rst_n)
        xoff_req |-> (paused && !$past(paused)));

    // R9: pause-off only from the paused condition, and it clears the level
    a_r9_xon_clears_pause: assert property (@(posedge clk) disable iff (!rst_n)
        xon_req |-> (!paused && $past(paused)));

    // R8, R9: the two requests never coincide
    a_r8_req_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(xoff_req && xon_req));

endmodule

bind rx_ring_mgr rx_ring_mgr_chk #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .prod_idx    (prod_idx),
    .desc_we     (desc_we),
    .desc_status (desc_status),
    .drop_count  (drop_count),
    .xoff_req    (xoff_req),
    .xon_req     (xon_req),
    .paused      (paused)
);

// File: tb/rx_ring_mgr_bench.sv
module rx_ring_mgr_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        buf_we;
    logic [18:0] buf_addr;
    logic [7:0]  buf_wdata;
    logic        desc_we;
    logic [7:0]  desc_idx;
    logic [31:0] desc_status;
    logic [15:0] prod_idx;
    logic        xoff_req;
    logic        xon_req;
    logic        paused;
    logic [15:0] drop_count;

    always #2 clk = ~clk;

    rx_ring_mgr u_rx_ring_mgr (
        .clk (clk), .rst_n (rst_n),
        .cfg_we (cfg_we), .cfg_addr (cfg_addr), .cfg_wdata (cfg_wdata),
        .in_valid (in_valid), .in_data (in_data), .in_last (in_last),
        .buf_we (buf_we), .buf_addr (buf_addr), .buf_wdata (buf_wdata),
        .desc_we (desc_we), .desc_idx (desc_idx), .desc_status (desc_status),
        .prod_idx (prod_idx), .xoff_req (xoff_req), .xon_req (xon_req),
        .paused (paused), .drop_count (drop_count)
    );

    int checks = 0;
    int errors = 0;
    logic [26:0] buf_q[$];
    logic [19:0] desc_q[$];

    int m_prod = 0, m_cons = 0, m_ptr = 0, m_drop = 0, m_max = 1536;
    bit m_pad = 1'b0;
    int xoff_seen = 0, xon_seen = 0;
    int last_idx = -1, last_len = -1;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int m_free();
        int occ;
        occ = (m_prod - m_cons) & 32'hFFFF;
        return (occ >= 256) ? 0 : 256 - occ;
    endfunction

    // Monitor: pop expected items as the design produces them
    always @(negedge clk) begin
        if (rst_n) begin
            if (buf_we) begin
                if (buf_q.size() == 0) begin
                    chk(1'b0, "R3 unexpected buffer write", int'(buf_addr), -1);
                end else begin
                    logic [26:0] e;
                    e = buf_q.pop_front();
                    chk({buf_addr, buf_wdata} == e, "R3 buffer write",
                        int'({buf_addr, buf_wdata}), int'(e));
                end
            end
            if (desc_we) begin
                last_idx = int'(desc_idx);
                last_len = int'(desc_status[27:16]);
                if (desc_q.size() == 0) begin
                    chk(1'b0, "R2 unexpected descriptor write", int'(desc_idx), -1);
                end else begin
                    logic [19:0] d;
                    d = desc_q.pop_front();
                    chk((desc_idx == d[19:12]) && (desc_status == {4'd0, d[11:0], 16'd0}),
                        "R2 descriptor write", int'({desc_idx, desc_status[27:16]}), int'(d));
                end
            end
            if (xoff_req) xoff_seen++;
            if (xon_req) xon_seen++;
        end
    end

    // Driver: pushes expected items, then drives the bytes
    task automatic send_frame(input int n, input int seed);
        bit room, keep;
        int pad;
        room = (m_free() != 0);
        keep = room && (n <= m_max);
        pad = m_pad ? 2 : 0;
        if (keep) desc_q.push_back({m_ptr[7:0], 12'(n + pad)});
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (room && (pad + i < 2048))
                buf_q.push_back({m_ptr[7:0], 11'(pad + i), 8'(seed + i)});
            in_valid = 1'b1;
            in_data = 8'(seed + i);
            in_last = (i == n - 1);
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last = 1'b0;
        if (keep) begin
            m_prod = (m_prod + 1) & 32'hFFFF;
            m_ptr = (m_ptr + 1) % 256;
        end else begin
            m_drop++;
        end
        repeat (2) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (a)
            2'd0: m_pad = d[1];
            2'd1: m_max = int'(d[11:0]);
            2'd3: m_cons = int'(d[15:0]);
            default: ;
        endcase
        repeat (2) @(negedge clk);
    endtask

    bit done = 1'b0;

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog R1..all actual=timeout expected=complete");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(prod_idx == 0, "R1 producer after reset", int'(prod_idx), 0);
        chk(drop_count == 0, "R1 drop count after reset", int'(drop_count), 0);
        chk(!paused && !xoff_req && !xon_req, "R1 pause outputs after reset", int'(paused), 0);
        chk(!buf_we && !desc_we, "R1 no writes after reset", int'({buf_we, desc_we}), 0);

        // R2, R3: plain frames, including a single-byte frame
        send_frame(4, 8'h10);
        send_frame(1, 8'h40);
        chk(last_len == 1, "R2 single-byte length", last_len, 1);
        chk(prod_idx == 16'd2, "R4 producer after two frames", int'(prod_idx), 2);

        // R5: alignment pad counted in the length
        cfg_write(2'd0, 32'h2);
        send_frame(5, 8'h60);
        chk(last_len == 7, "R5 padded length", last_len, 7);

        // R6: default maximum length boundary
        send_frame(1536, 8'h00);
        chk(last_len == 1538, "R6 max-length frame accepted", last_len, 1538);
        send_frame(1537, 8'h11);
        chk(drop_count == 16'd1, "R6 oversize drop counted", int'(drop_count), 1);
        chk(prod_idx == 16'd4, "R6 producer unchanged by drop", int'(prod_idx), 4);

        // R3: frame running past the buffer end
        cfg_write(2'd1, 32'd4095);
        send_frame(2050, 8'h22);
        chk(last_len == 2052, "R3 length includes unwritten tail", last_len, 2052);

        // R6: programmed limit
        cfg_write(2'd1, 32'd20);
        send_frame(20, 8'h33);
        send_frame(21, 8'h44);
        chk(drop_count == 16'd2, "R6 programmed limit drop", int'(drop_count), 2);
        chk(prod_idx == 16'd6, "R6 producer after limit test", int'(prod_idx), 6);

        // R8: fill toward the low threshold
        while (m_prod < 250) send_frame(3, m_prod);
        chk(!paused && xoff_seen == 0, "R8 not paused at free 6", xoff_seen, 0);
        send_frame(3, 8'h55);
        chk(paused && xoff_seen == 1, "R8 pause-on at free 5", xoff_seen, 1);

        // R4: fill the ring completely
        while (m_prod < 256) send_frame(3, m_prod);
        chk(prod_idx == 16'd256, "R4 producer past 255", int'(prod_idx), 256);
        chk(last_idx == 255, "R4 last descriptor index", last_idx, 255);

        // R7: ring full drop
        send_frame(3, 8'h66);
        chk(drop_count == 16'd3, "R7 full-ring drop counted", int'(drop_count), 3);
        chk(prod_idx == 16'd256, "R7 producer unchanged when full", int'(prod_idx), 256);

        // R9, R10: release buffers through the consumer index
        cfg_write(2'd3, 32'd10);
        chk(paused && xon_seen == 0, "R9 still paused at free 10", xon_seen, 0);
        cfg_write(2'd3, 32'd16);
        chk(!paused && xon_seen == 1, "R9 pause-off at free 16", xon_seen, 1);

        // R4: pointer wraps to descriptor 0
        send_frame(3, 8'h77);
        chk(last_idx == 0, "R4 descriptor pointer wrap", last_idx, 0);
        chk(prod_idx == 16'd257, "R4 producer after wrap", int'(prod_idx), 257);

        // R7, R10: consumer ahead of producer leaves no room
        cfg_write(2'd3, 32'd300);
        chk(xoff_seen == 2, "R10 consumer write drives free to 0", xoff_seen, 2);
        send_frame(2, 8'h88);
        chk(drop_count == 16'd4, "R7 modulo occupancy drop", int'(drop_count), 4);
        cfg_write(2'd3, 32'd257);
        chk(xon_seen == 2 && !paused, "R9 pause-off after release", xon_seen, 2);
        send_frame(2, 8'h99);
        chk(last_idx == 1, "R2 accepted after release", last_idx, 1);

        repeat (4) @(negedge clk);
        chk(buf_q.size() == 0, "R3 all buffer writes seen", buf_q.size(), 0);
        chk(desc_q.size() == 0, "R2 all descriptor writes seen", desc_q.size(), 0);
        chk(int'(drop_count) == m_drop, "R6 drop total", int'(drop_count), m_drop);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule